// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Gate

This block sits on the register bus of a two-channel disk host card. It decides which drive interrupts reach the processor. Each channel has its own enable flag. The flag is not held in a readable bit. Software sets it by writing to that channel's interrupt-control location, whatever value it writes. Software clears it by reading that same location. To route the interrupt to one channel only, software writes that channel's location and reads the other channel's location.

A status location for each channel shows the drive's raw request, with no gating. A card-level pending output ORs the two raw requests, so a poller can see activity even while both channels are masked. One configuration byte at the bottom of the map does two jobs. It opens the extended address window, and it steers the card's single DMA handshake to one of the two channels. Writing zero to that byte also produces a one-cycle pulse that resets the boot-ROM page pointer. A fixed 4-bit board code can be read one bit per byte, which lets software identify the card variant.

Top module: `dskirq_ctrl`

## Requirements
- R1: A write to a channel's interrupt-control location sets that channel's enable flag, whatever the data. Channel 0 is at 0x2200 and channel 1 at 0x3200. The flag takes effect on the clock edge that captures the access.
- R2: A read of a channel's interrupt-control location clears that channel's enable flag. The read returns 0x00.
- R3: `irq_o` is high exactly when some channel has both its enable flag set and its request input high.
- R4: The status locations are 0x2290 for channel 0 and 0x3290 for channel 1. Each reads the channel's raw request in bit 0, with 0 in bits 7..1. `pend_o` is the OR of both raw requests, regardless of the enables.
- R5: The configuration byte at 0x0000 reads back the last value written. Bit 5 drives `win_open_o` and bit 0 drives `dma_ch_o` (0 selects channel 0, 1 selects channel 1).
- R6: Writing 0x00 to the configuration byte raises `rom_rst_o` for exactly one cycle. Writing any other value leaves it low.
- R7: The board code is read from bit 0 of the bytes at 0x2280, 0x2284, 0x2288 and 0x228C, least significant bit first, with bits 7..1 reading 0. The default code is 3.
- R8: After reset both enable flags and the configuration byte are 0, and `irq_o`, `win_open_o`, `dma_ch_o` and `rom_rst_o` are low.
- R9: A read of an unmapped address returns 0x00. A write to an unmapped address changes no flag and no register.
- R10: An access to one channel's interrupt-control location leaves the other channel's enable flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address within the card window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the access edge |
| drv_req_i | input | 2 | Raw interrupt request from each drive channel |
| irq_o | output | 1 | Gated interrupt to the processor |
| pend_o | output | 1 | OR of raw channel requests |
| win_open_o | output | 1 | Extended address window open |
| dma_ch_o | output | 1 | Channel receiving the DMA handshake |
| rom_rst_o | output | 1 | One-cycle boot-ROM page pointer reset |

## Verification
The assertions check the access side effects on every cycle. A write to a control location must be followed by a set flag, and a read by a cleared flag. An access aimed at one channel must leave the other channel's flag alone. Configuration outputs may change only after a configuration write, and the ROM reset pulse may appear only after a zero write. The value-level behaviour needs the bench's scenarios: the gating of the interrupt under mixed enable and request patterns, the readback of status bits and board code bits, and the way unmapped accesses are ignored.

// File: rtl/dskirq_pkg.sv
package dskirq_pkg;

  localparam int ADDR_W     = 14;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = 4;
  localparam int CODE_IDX_W = $clog2(CODE_W);

  // per-channel window layout
  localparam int CH_BASE0   = 32'h2000;
  localparam int CH_STRIDE  = 32'h1000;
  localparam int CTRL_OFS   = 32'h0200;
  localparam int STAT_OFS   = 32'h0290;

  localparam logic [ADDR_W-1:0] CFG_ADDR  = '0;
  localparam logic [ADDR_W-1:0] CODE_BASE = 14'h2280;

  // configuration byte bit positions
  localparam int WIN_BIT = 5;
  localparam int DMA_BIT = 0;

  function automatic logic [ADDR_W-1:0] ctrl_addr(input int ch);
    return ADDR_W'(CH_BASE0 + ch * CH_STRIDE + CTRL_OFS);
  endfunction

  function automatic logic [ADDR_W-1:0] stat_addr(input int ch);
    return ADDR_W'(CH_BASE0 + ch * CH_STRIDE + STAT_OFS);
  endfunction

endpackage

// File: rtl/dskirq_decode.sv
module dskirq_decode
  import dskirq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NCH-1:0]        ctrl_hit_o,
  output logic [NCH-1:0]        stat_hit_o,
  output logic                  cfg_hit_o,
  output logic                  code_hit_o,
  output logic [CODE_IDX_W-1:0] code_idx_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctrl_hit_o[g] = (addr_i == ctrl_addr(g));
    assign stat_hit_o[g] = (addr_i == stat_addr(g));
  end

  assign cfg_hit_o = (addr_i == CFG_ADDR);

  // code bytes sit four bytes apart in one 16-byte slot
  assign code_hit_o = (addr_i[ADDR_W-1:4] == CODE_BASE[ADDR_W-1:4]) &&
                      (addr_i[1:0] == 2'b00);
  assign code_idx_o = addr_i[2 +: CODE_IDX_W];

endmodule

// File: rtl/dskirq_chan.sv
module dskirq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic req_i,
  output logic en_o,
  output logic gated_o
);

  logic en_q, en_d, en_ce;

  always_comb begin
    en_ce = set_i | clr_i;
    en_d  = en_q;
    if (set_i)      en_d = 1'b1;
    else if (clr_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o    = en_q;
  assign gated_o = en_q & req_i;

endmodule

// File: rtl/dskirq_cfg.sv
module dskirq_cfg
  import dskirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              rom_rst_o
);

  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              pulse_q, pulse_d;

  always_comb begin
    cfg_d   = wr_i ? wdata_i : cfg_q;
    pulse_d = wr_i && (wdata_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign cfg_o     = cfg_q;
  assign rom_rst_o = pulse_q;

endmodule

// File: rtl/dskirq_ctrl.sv
module dskirq_ctrl
  import dskirq_pkg::*;
#(
  parameter int                NCH        = 2,
  parameter logic [CODE_W-1:0] BOARD_CODE = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    drv_req_i,
  output logic              irq_o,
  output logic              pend_o,
  output logic              win_open_o,
  output logic              dma_ch_o,
  output logic              rom_rst_o
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NCH-1:0]        ctrl_hit, stat_hit;
  logic                  cfg_hit, code_hit;
  logic [CODE_IDX_W-1:0] code_idx;

  dskirq_decode #(.NCH(NCH)) dec_i (
    .addr_i    (bus_addr),
    .ctrl_hit_o(ctrl_hit),
    .stat_hit_o(stat_hit),
    .cfg_hit_o (cfg_hit),
    .code_hit_o(code_hit),
    .code_idx_o(code_idx)
  );

  logic rd_acc, wr_acc;
  assign wr_acc = bus_sel &  bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  logic [NCH-1:0] en_vec, gated_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dskirq_chan chan_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (wr_acc & ctrl_hit[g]),
      .clr_i  (rd_acc & ctrl_hit[g]),
      .req_i  (drv_req_i[g]),
      .en_o   (en_vec[g]),
      .gated_o(gated_vec[g])
    );
  end

  logic [DATA_W-1:0] cfg_val;

  dskirq_cfg cfg_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (wr_acc & cfg_hit),
    .wdata_i  (bus_wdata),
    .cfg_o    (cfg_val),
    .rom_rst_o(rom_rst_o)
  );

  // read mux; control locations read as zero
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (cfg_hit)  rd_d = cfg_val;
    if (code_hit) rd_d[0] = BOARD_CODE[code_idx];
    for (int c = 0; c < NCH; c++) begin
      if (stat_hit[c]) rd_d[0] = drv_req_i[c];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= '0;
    else if (rd_acc) rd_q <= rd_d;
  end

  assign bus_rdata  = rd_q;
  assign irq_o      = |gated_vec;
  assign pend_o     = |drv_req_i;
  assign win_open_o = cfg_val[WIN_BIT];
  assign dma_ch_o   = cfg_val[DMA_BIT];

endmodule

// File: rtl/dskirq_ctrl_chk.sv
module dskirq_ctrl_chk
  import dskirq_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NCH-1:0]    en_vec,
  input logic              irq_o,
  input logic              pend_o,
  input logic [NCH-1:0]    drv_req_i,
  input logic              win_open_o,
  input logic              dma_ch_o,
  input logic              rom_rst_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_p
    // R1
    a_r1_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ctrl_addr(g)) |=> en_vec[g]);
    // R2
    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ctrl_addr(g)) |=> !en_vec[g]);
    // R10
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_addr == ctrl_addr(g)) |=> $stable(en_vec[g]));
  end

  // R3
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq_o);
  // R4
  a_r4_pend_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req_i != '0) |-> pend_o);
  // R5
  a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == CFG_ADDR) |=>
      ($stable(win_open_o) && $stable(dma_ch_o)));
  // R6
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rst_o |-> $past(bus_sel && bus_wr && bus_addr == CFG_ADDR && bus_wdata == '0));

endmodule

bind dskirq_ctrl dskirq_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_vec    (en_vec),
  .irq_o     (irq_o),
  .pend_o    (pend_o),
  .drv_req_i (drv_req_i),
  .win_open_o(win_open_o),
  .dma_ch_o  (dma_ch_o),
  .rom_rst_o (rom_rst_o)
);

// File: tb/dskirq_ctrl_tb_top.sv
module dskirq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] drv_req = '0;
  logic       irq, pend, win_open, dma_ch, rom_rst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dskirq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .drv_req_i (drv_req),
    .irq_o     (irq),
    .pend_o    (pend),
    .win_open_o(win_open),
    .dma_ch_o  (dma_ch),
    .rom_rst_o (rom_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R8 irq", int'(irq), 0);
    chk("R8 win", int'(win_open), 0);
    chk("R8 dma", int'(dma_ch), 0);
    chk("R8 romrst", int'(rom_rst), 0);
    bus_read(14'h0000, d);
    chk("R8 cfg", int'(d), 0);
    drv_req = 2'b11;
    @(negedge clk);
    chk("R8 flags clear", int'(irq), 0);
    drv_req = 2'b00;
  endtask

  task automatic t_enable();
    logic [7:0] d;
    drv_req = 2'b01;
    bus_write(14'h2200, 8'hA5);
    chk("R1 set any data", int'(irq), 1);
    chk("R3 gated on", int'(irq), 1);
    bus_read(14'h2200, d);
    chk("R2 read clears", int'(irq), 0);
    chk("R2 read value", int'(d), 0);
    bus_write(14'h2200, 8'h00);
    chk("R1 set zero data", int'(irq), 1);
    drv_req = 2'b00;
    @(negedge clk);
    chk("R3 no request", int'(irq), 0);
    bus_read(14'h2200, d);
  endtask

  task automatic t_indep();
    logic [7:0] d;
    bus_write(14'h2200, 8'h01);
    drv_req = 2'b10;
    @(negedge clk);
    chk("R3 other chan masked", int'(irq), 0);
    bus_write(14'h3200, 8'h00);
    chk("R1 chan1 set", int'(irq), 1);
    bus_read(14'h2200, d);
    chk("R10 chan1 kept", int'(irq), 1);
    drv_req = 2'b01;
    @(negedge clk);
    chk("R10 chan0 cleared", int'(irq), 0);
    bus_write(14'h2200, 8'h00);
    bus_read(14'h3200, d);
    chk("R10 chan0 kept", int'(irq), 1);
    bus_read(14'h2200, d);
    drv_req = 2'b00;
  endtask

  task automatic t_status();
    logic [7:0] d;
    drv_req = 2'b10;
    bus_read(14'h2290, d);
    chk("R4 stat0 low", int'(d), 0);
    bus_read(14'h3290, d);
    chk("R4 stat1 high", int'(d), 1);
    chk("R4 pend masked", int'(pend), 1);
    drv_req = 2'b01;
    bus_read(14'h2290, d);
    chk("R4 stat0 high", int'(d), 1);
    drv_req = 2'b00;
    @(negedge clk);
    chk("R4 pend idle", int'(pend), 0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    bus_write(14'h0000, 8'h21);
    chk("R5 win", int'(win_open), 1);
    chk("R5 dma", int'(dma_ch), 1);
    chk("R6 no pulse nonzero", int'(rom_rst), 0);
    bus_read(14'h0000, d);
    chk("R5 readback", int'(d), 8'h21);
    bus_write(14'h0000, 8'h20);
    chk("R5 dma chan0", int'(dma_ch), 0);
    bus_write(14'h0000, 8'h00);
    chk("R6 pulse", int'(rom_rst), 1);
    chk("R5 win closed", int'(win_open), 0);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(rom_rst), 0);
  endtask

  task automatic t_code();
    logic [7:0] d;
    logic [3:0] code;
    for (int k = 0; k < 4; k++) begin
      bus_read(14'h2280 + 14'(4 * k), d);
      code[k] = d[0];
      chk("R7 upper bits", int'(d[7:1]), 0);
    end
    chk("R7 code", int'(code), 3);
    bus_read(14'h2281, d);
    chk("R9 unmapped read", int'(d), 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    bus_write(14'h0000, 8'h21);
    drv_req = 2'b11;
    bus_write(14'h1234, 8'hFF);
    bus_write(14'h2201, 8'hFF);
    chk("R9 no enable", int'(irq), 0);
    bus_read(14'h0000, d);
    chk("R9 cfg unchanged", int'(d), 8'h21);
    drv_req = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_indep();
    t_status();
    t_cfg();
    t_code();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule